// File: doc/BRIEF.md
# Buffered VRAM Data Port

This block is the data-register path of a video controller. A host access, read or write, is applied to the current video memory address that the block receives. Addresses in the palette window go to a small internal palette RAM of 32 six-bit colour entries. All other addresses go to an external pattern/nametable memory through a simple request interface. Address mirroring inside that external space is the external memory's job.

Reads outside the palette window are delayed by one access. The byte returned is the one held in a one-deep read buffer, and the access then refills the buffer from the addressed location. Palette reads return their entry immediately, with the top two bits taken from the last bus value. The buffer is still refilled, from the nametable byte that lies 0x1000 below the palette address. Every accepted access reports the next address, stepped by 1 or by 32 and wrapped in 15 bits, so that the owning register file can store it.

Top module: `vram_data_port`

## Requirements
- R1: After reset, `acc_ready` is 1, `rd_valid`, `addr_upd` and `mem_req` are 0, and the read buffer holds 0x00. The first non-palette read therefore returns 0x00.
- R2: An accepted read whose address bits 13:8 are below 0x3F returns the buffered byte on `rd_data`, with `rd_valid` high one cycle after acceptance. In that same cycle it issues `mem_req` with `mem_we`=0 and `mem_addr` equal to address bits 13:0. The returned byte is then stored as the buffer.
- R3: An address is in the palette window when its bits 13:8 equal 0x3F; bit 14 is ignored. A palette read returns `{bus_hi, entry[5:0]}` one cycle after acceptance, where `bus_hi` is the value sampled at acceptance.
- R4: A palette read refills the buffer with a memory read at address bits 13:0 minus 0x1000.
- R5: The palette index is address bits 4:0. When index bits 1:0 are both zero, index bit 4 is cleared. This applies to both reads and writes, so 0x10/0x14/0x18/0x1C share storage with 0x00/0x04/0x08/0x0C.
- R6: A write outside the palette window issues one `mem_req` cycle with `mem_we`=1, `mem_addr` = address bits 13:0 and `mem_wdata` = the written byte. A palette write stores data bits 5:0, discards bits 7:6, and issues no memory request.
- R7: Every accepted access, read or write, pulses `addr_upd` one cycle later. `addr_next` = (address + 32) mod 2^15 when `inc32` was 1, and (address + 1) mod 2^15 otherwise.
- R8: The memory request lasts one cycle and starts one cycle after acceptance. Read data is taken on the cycle after the request. `acc_ready` is low for 2 cycles after a read, 1 cycle after a memory write, and 0 cycles after a palette write.
- R9: `acc_valid` while `acc_ready` is low is ignored. It produces no `rd_valid`, no `addr_upd` and no memory request, and it leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| cur_addr | input | 15 | Current video memory address |
| inc32 | input | 1 | Step select: 1 = 32, 0 = 1 |
| bus_hi | input | 2 | Upper two bits of the last host bus value |
| acc_ready | output | 1 | Port can accept an access |
| rd_data | output | 8 | Read result, held until the next read |
| rd_valid | output | 1 | One-cycle pulse with read result |
| addr_next | output | 15 | Stepped address |
| addr_upd | output | 1 | One-cycle pulse: store `addr_next` |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 14 | External memory address |
| mem_wdata | output | 8 | External write data |
| mem_rdata | input | 8 | External read data, valid the cycle after a read request |

## Verification
A wrong buffer value stays hidden until the following non-palette read, and then shows on `rd_data` one access late. For that reason the bench follows each refill with a read and compares against its own model of the buffer. A wrong palette fold shows up as a readback that differs from the entry last written through the aliased index; this appears on the first read of that index after the write. Stepping and request errors appear on `addr_next` and the `mem_*` pins in the first cycle after acceptance. Handshake errors show on `acc_ready` within two cycles.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
    localparam int VA_W      = 15;
    localparam int MA_W      = 14;
    localparam int D_W       = 8;
    localparam int PAL_IDX_W = 5;
    localparam int PAL_W     = 6;
    localparam int HI_W      = D_W - PAL_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } port_st_e;

    typedef struct packed {
        port_st_e          st;
        logic [D_W-1:0]    rbuf;
        logic [D_W-1:0]    rd_data;
        logic              rd_valid;
        logic              addr_upd;
        logic [VA_W-1:0]   addr_next;
        logic              mem_req;
        logic              mem_we;
        logic [MA_W-1:0]   mem_addr;
        logic [D_W-1:0]    mem_wdata;
    } port_regs_t;
endpackage

// File: rtl/vram_pal_ram.sv
module vram_pal_ram #(
    parameter int IDX_W = 5,
    parameter int W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    localparam int DEPTH = 1 << IDX_W;

    // Entries whose low two index bits are zero fold onto the lower half.
    function automatic logic [IDX_W-1:0] fold(input logic [IDX_W-1:0] i);
        logic [IDX_W-1:0] r;
        r = i;
        if (i[1:0] == 2'b00) r[IDX_W-1] = 1'b0;
        return r;
    endfunction

    logic [W-1:0]     ent_q [DEPTH];
    logic [W-1:0]     ent_d [DEPTH];
    logic [IDX_W-1:0] slot;

    assign slot  = fold(idx);
    assign rdata = ent_q[slot];

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            ent_d[e] = ent_q[e];
            if (we && (slot == IDX_W'(e))) ent_d[e] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) ent_q[e] <= ent_d[e];
        end
    end
endmodule

// File: rtl/vram_region_dec.sv
module vram_region_dec #(
    parameter int                 MA_W       = 14,
    parameter int                 TAG_W      = 6,
    parameter logic [TAG_W-1:0]   PAL_TAG    = 6'h3F,
    parameter logic [MA_W-1:0]    REFILL_OFS = 14'h1000
) (
    input  logic [MA_W-1:0] addr,
    output logic            is_pal,
    output logic [MA_W-1:0] refill_addr
);
    assign is_pal      = (addr[MA_W-1 -: TAG_W] == PAL_TAG);
    assign refill_addr = is_pal ? (addr - REFILL_OFS) : addr;
endmodule

// File: rtl/vram_addr_step.sv
module vram_addr_step #(
    parameter int VA_W      = 15,
    parameter int WIDE_STEP = 32
) (
    input  logic [VA_W-1:0] cur,
    input  logic            wide,
    output logic [VA_W-1:0] nxt
);
    localparam logic [VA_W-1:0] STEP_W = VA_W'(WIDE_STEP);
    localparam logic [VA_W-1:0] STEP_N = VA_W'(1);

    assign nxt = cur + (wide ? STEP_W : STEP_N);
endmodule

// File: rtl/vram_data_port.sv
module vram_data_port
    import vram_port_pkg::*;
#(
    parameter int WIDE_STEP = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [D_W-1:0]  acc_wdata,
    input  logic [VA_W-1:0] cur_addr,
    input  logic            inc32,
    input  logic [HI_W-1:0] bus_hi,
    output logic            acc_ready,
    output logic [D_W-1:0]  rd_data,
    output logic            rd_valid,
    output logic [VA_W-1:0] addr_next,
    output logic            addr_upd,
    output logic            mem_req,
    output logic            mem_we,
    output logic [MA_W-1:0] mem_addr,
    output logic [D_W-1:0]  mem_wdata,
    input  logic [D_W-1:0]  mem_rdata
);
    port_regs_t       r_q, r_d;
    logic             is_pal;
    logic [MA_W-1:0]  refill_addr;
    logic [VA_W-1:0]  step_addr;
    logic [PAL_W-1:0] pal_rdata;
    logic             pal_we;
    logic             accept;

    vram_region_dec #(.MA_W(MA_W)) u_dec (
        .addr        (cur_addr[MA_W-1:0]),
        .is_pal      (is_pal),
        .refill_addr (refill_addr)
    );

    vram_addr_step #(.VA_W(VA_W), .WIDE_STEP(WIDE_STEP)) u_step (
        .cur  (cur_addr),
        .wide (inc32),
        .nxt  (step_addr)
    );

    vram_pal_ram #(.IDX_W(PAL_IDX_W), .W(PAL_W)) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .idx   (cur_addr[PAL_IDX_W-1:0]),
        .wdata (acc_wdata[PAL_W-1:0]),
        .rdata (pal_rdata)
    );

    assign acc_ready = (r_q.st == ST_IDLE);
    assign accept    = acc_valid && acc_ready;
    assign pal_we    = accept && acc_write && is_pal;

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        r_d.addr_upd = 1'b0;
        r_d.mem_req  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.addr_upd  = 1'b1;
                    r_d.addr_next = step_addr;
                    if (acc_write) begin
                        if (!is_pal) begin
                            r_d.mem_req   = 1'b1;
                            r_d.mem_we    = 1'b1;
                            r_d.mem_addr  = cur_addr[MA_W-1:0];
                            r_d.mem_wdata = acc_wdata;
                            r_d.st        = ST_REQ;
                        end
                    end else begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = is_pal ? {bus_hi, pal_rdata} : r_q.rbuf;
                        r_d.mem_req  = 1'b1;
                        r_d.mem_we   = 1'b0;
                        r_d.mem_addr = refill_addr;
                        r_d.st       = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                r_d.st = r_q.mem_we ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                r_d.rbuf = mem_rdata;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data   = r_q.rd_data;
    assign rd_valid  = r_q.rd_valid;
    assign addr_next = r_q.addr_next;
    assign addr_upd  = r_q.addr_upd;
    assign mem_req   = r_q.mem_req;
    assign mem_we    = r_q.mem_we;
    assign mem_addr  = r_q.mem_addr;
    assign mem_wdata = r_q.mem_wdata;
endmodule

// File: rtl/vram_data_port_chk.sv
module vram_data_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [14:0] cur_addr,
    input logic        inc32,
    input logic [1:0]  bus_hi,
    input logic        acc_ready,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic [14:0] addr_next,
    input logic        addr_upd,
    input logic        mem_req
);
    // R8
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !acc_ready);

    // R7
    step_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=>
            (addr_upd && addr_next == 15'($past(cur_addr) + ($past(inc32) ? 15'd32 : 15'd1))));

    // R9
    busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready) |=> (!addr_upd && !rd_valid));

    // R3
    pal_hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write && cur_addr[13:8] == 6'h3F) |=>
            (rd_valid && rd_data[7:6] == $past(bus_hi)));

    // R6
    pal_write_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_write && cur_addr[13:8] == 6'h3F) |=>
            (!mem_req && acc_ready));
endmodule

bind vram_data_port vram_data_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .cur_addr  (cur_addr),
    .inc32     (inc32),
    .bus_hi    (bus_hi),
    .acc_ready (acc_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .addr_next (addr_next),
    .addr_upd  (addr_upd),
    .mem_req   (mem_req)
);

// File: tb/vram_data_port_tb.sv
module vram_data_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [14:0] cur_addr = '0;
    logic        inc32 = 1'b0;
    logic [1:0]  bus_hi = '0;
    logic [7:0]  mem_rdata = '0;
    logic        acc_ready, rd_valid, addr_upd, mem_req, mem_we;
    logic [7:0]  rd_data, mem_wdata;
    logic [14:0] addr_next;
    logic [13:0] mem_addr;

    always #4 clk = ~clk;

    vram_data_port u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .cur_addr(cur_addr), .inc32(inc32), .bus_hi(bus_hi),
        .acc_ready(acc_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .addr_next(addr_next), .addr_upd(addr_upd), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] ext_f(input logic [13:0] a);
        return 8'(a[7:0] * 8'd3) ^ {a[13:8], 2'b01};
    endfunction

    function automatic logic [4:0] fold(input logic [4:0] i);
        return (i[1:0] == 2'b00) ? (i & 5'h0F) : i;
    endfunction

    // External memory model: data valid the cycle after a read request.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= ext_f(mem_addr);
    end

    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] m_buf = 8'h00;
    logic [5:0] m_pal [32];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; returns at the falling edge after acceptance.
    task automatic go(input bit wr, input logic [14:0] a, input logic [7:0] d,
                      input bit w32, input logic [1:0] bh);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; cur_addr = a; acc_wdata = d;
        inc32 = w32; bus_hi = bh;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [14:0] a, input bit w32, input logic [1:0] bh);
        bit          pal;
        logic [7:0]  exp;
        logic [13:0] ra;
        pal = (a[13:8] == 6'h3F);
        exp = pal ? {bh, m_pal[fold(a[4:0])]} : m_buf;
        ra  = pal ? 14'(a[13:0] - 14'h1000) : a[13:0];
        go(1'b0, a, 8'h00, w32, bh);
        chk(pal ? "R3 R5 palette read data" : "R2 buffered read data", 32'(rd_data), 32'(exp));
        chk("R2 rd_valid pulse", 32'(rd_valid), 1);
        chk("R7 addr_upd on read", 32'(addr_upd), 1);
        chk("R7 addr_next on read", 32'(addr_next), 32'(15'(a + (w32 ? 15'd32 : 15'd1))));
        chk("R2 R8 read request issued", 32'({mem_req, mem_we}), 32'b10);
        chk(pal ? "R4 refill address" : "R2 refill address", 32'(mem_addr), 32'(ra));
        chk("R8 busy after read", 32'(acc_ready), 0);
        @(negedge clk);
        chk("R8 request one cycle", 32'({mem_req, acc_ready, rd_valid, addr_upd}), 0);
        @(negedge clk);
        chk("R8 ready after refill", 32'(acc_ready), 1);
        m_buf = ext_f(ra);
    endtask

    task automatic wr_chk(input logic [14:0] a, input logic [7:0] d, input bit w32);
        bit pal;
        pal = (a[13:8] == 6'h3F);
        if (pal) m_pal[fold(a[4:0])] = d[5:0];
        go(1'b1, a, d, w32, 2'b00);
        chk("R7 addr_next on write", 32'({addr_upd, addr_next}),
            32'({1'b1, 15'(a + (w32 ? 15'd32 : 15'd1))}));
        chk("R6 no read pulse on write", 32'(rd_valid), 0);
        if (pal) begin
            chk("R6 R8 palette write no request, ready", 32'({mem_req, acc_ready}), 32'b01);
        end else begin
            chk("R6 memory write request", 32'({mem_req, mem_we, mem_addr, mem_wdata}),
                32'({1'b1, 1'b1, a[13:0], d}));
            chk("R8 busy after memory write", 32'(acc_ready), 0);
            @(negedge clk);
            chk("R8 memory write done", 32'({mem_req, acc_ready}), 32'b01);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_pal[i] = 6'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", 32'({acc_ready, rd_valid, addr_upd, mem_req}), 32'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({acc_ready, mem_req}), 32'b10);
        // R1: first read returns the cleared buffer
        rd_chk(15'h0123, 1'b0, 2'b00);

        // R2 R7: sweep of non-palette reads, both step modes, bit 14 varied
        for (int i = 0; i < 96; i++) begin
            logic [14:0] a;
            a = {i[2], 14'((i * 1237) % 16128)};
            rd_chk(a, i[0], 2'(i));
        end
        rd_chk(15'h3EFF, 1'b0, 2'b11);

        // R5 R6: every palette index written, through varied upper bits
        for (int i = 0; i < 32; i++) begin
            logic [14:0] a;
            a = {i[1], 6'h3F, 3'(i * 5), 5'(i)};
            wr_chk(a, 8'(i * 37 + 11), i[2]);
        end
        // R3 R4 R5: every palette index read back
        for (int i = 0; i < 32; i++) begin
            logic [14:0] a;
            a = {i[3], 6'h3F, 3'(i * 3), 5'(31 - i)};
            rd_chk(a, i[0], 2'(i + 1));
        end
        // R4: the next plain read returns the byte refilled below the palette
        rd_chk(15'h0456, 1'b0, 2'b00);

        // R6: external memory writes
        for (int i = 0; i < 16; i++) begin
            wr_chk(15'((i * 997) % 16128), 8'(i * 29 + 7), i[0]);
        end
        // buffer untouched by writes
        rd_chk(15'h1000, 1'b0, 2'b00);

        // R7: wrap at the top of the 15-bit space
        rd_chk(15'h7FFF, 1'b0, 2'b10);
        rd_chk(15'h7FF0, 1'b1, 2'b01);
        wr_chk(15'h7FE5, 8'hA5, 1'b1);

        // R9: strobe held while busy is ignored
        rd_chk(15'h0200, 1'b0, 2'b00);
        go(1'b0, 15'h0300, 8'h00, 1'b0, 2'b00);
        chk("R2 read before busy test", 32'(rd_data), 32'(m_buf));
        m_buf = ext_f(14'h0300);
        acc_valid = 1'b1; cur_addr = 15'h0555;
        @(negedge clk);
        chk("R9 ignored while requesting", 32'({addr_upd, rd_valid, mem_req}), 0);
        @(negedge clk);
        chk("R9 ignored while waiting", 32'({addr_upd, rd_valid, mem_req}), 0);
        acc_valid = 1'b0;
        rd_chk(15'h0010, 1'b0, 2'b00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule